// File: doc/BRIEF.md
# Partitioned SIMD Integer Lane ALU

The block is a 128-bit integer vector ALU whose datapath is split at run time into sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. All lanes share one decoded opcode and perform it in lockstep on two source vectors. The operations are wrapping add, wrapping subtract, equality and signed greater-than compares, and signed minimum and maximum. A single partitioned adder serves every operation: carries are forced at the boundaries of the selected lane width, and the compare and min/max results come from the per-lane difference.

A per-lane write mask chooses which destination lanes take the computed value. For lanes that are masked off, a mode input either merges (the old destination value passes through) or zeroes them. The final vector is registered, so a result and its valid flag appear one clock after the operands are presented.

Top module: `simd_lane_alu`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is all zeros.
- R2: valid_o equals valid_i of the previous clock. result_o loads only on a clock where valid_i is 1 and holds its value otherwise.
- R3: esize_i selects the lane width: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, 2 and 3 both give 4 lanes of 32 bits. Lane i occupies bits [i*W +: W].
- R4: op_i 0 gives a+b and op_i 1 gives a-b, each modulo 2^W per lane. No carry or borrow crosses a lane boundary.
- R5: op_i 2 (a equal to b) and op_i 3 (a greater than b, signed) write all ones to a lane where the condition holds and all zeros where it does not.
- R6: op_i 4 writes the signed minimum of a and b to each lane, and op_i 5 writes the signed maximum.
- R7: op_i 6 and op_i 7 write zero to every enabled lane.
- R8: Lane i uses mask_i bit i. Mask bits at or above the lane count of the current width have no effect.
- R9: With zero_mode_i = 0, a lane whose mask bit is 0 receives the corresponding lane of dst_old_i.
- R10: With zero_mode_i = 1, a lane whose mask bit is 0 receives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| dst_old_i | input | 128 | Previous destination contents, used in merge mode |
| esize_i | input | 2 | Lane width select (0: 8, 1: 16, 2 or 3: 32 bits) |
| op_i | input | 3 | Operation code |
| mask_i | input | 16 | Per-lane write enable, bit i for lane i |
| zero_mode_i | input | 1 | 1: zero masked-off lanes, 0: keep old contents |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 128 | Registered result vector |

## Verification
The bench sets all-ones plus one in every byte and zero minus one in every halfword. A design that leaks a carry or borrow across a lane boundary corrupts the neighbouring lane. It compares 0x80 against 0x7F and mixed-sign words; a design that compared unsigned or took the overflow wrongly would choose the wrong minimum or maximum or flip a compare. It drives masks whose upper bits are set at 32-bit width, and in merge mode a design that indexed the mask by byte instead of by lane would write lanes it should preserve. Random vectors across every width, opcode, mask and mode are checked against a per-lane reference, and idle cycles confirm that the result holds.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMPEQ = 3'd2,
    OP_CMPGT = 3'd3,
    OP_MIN   = 3'd4,
    OP_MAX   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } alu_op_e;

  // log2 of bytes per lane: 8b -> 0, 16b -> 1, 32b (codes 2 and 3) -> 2
  function automatic logic [1:0] lane_lg(input logic [1:0] esize);
    case (esize)
      2'd0:    lane_lg = 2'd0;
      2'd1:    lane_lg = 2'd1;
      default: lane_lg = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/simd_part_adder.sv
module simd_part_adder #(
  parameter int unsigned BYTES = 16,
  localparam int unsigned W = BYTES * 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [BYTES-1:0] lane_start_i,
  input  logic             sub_i,
  output logic [W-1:0]     sum_o,
  output logic [BYTES-1:0] ovf_o
);
  logic [BYTES-1:0] carry;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic [7:0] bb;
    logic       cin;
    assign bb = sub_i ? ~b_i[k*8 +: 8] : b_i[k*8 +: 8];
    if (k == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_next
      // carry is cut at each lane start and replaced by the subtract injection
      assign cin = lane_start_i[k] ? sub_i : carry[k-1];
    end
    if (k < BYTES - 1) begin : g_mid
      assign {carry[k], sum_o[k*8 +: 8]} = {1'b0, a_i[k*8 +: 8]} + {1'b0, bb} + 9'(cin);
    end else begin : g_last
      assign carry[k] = 1'b0;
      assign sum_o[k*8 +: 8] = a_i[k*8 +: 8] + bb + 8'(cin);
    end
    assign ovf_o[k] = (a_i[k*8+7] == bb[7]) && (sum_o[k*8+7] != a_i[k*8+7]);
  end
endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags #(
  parameter int unsigned BYTES = 16,
  localparam int unsigned W = BYTES * 8
) (
  input  logic [W-1:0]     diff_i,
  input  logic [BYTES-1:0] ovf_i,
  input  logic [1:0]       lg_i,
  output logic [BYTES-1:0] lane_eq_o,
  output logic [BYTES-1:0] lane_lt_o
);
  logic [BYTES-1:0] byte_zero;

  for (genvar k = 0; k < BYTES; k++) begin : g_z
    assign byte_zero[k] = (diff_i[k*8 +: 8] == 8'h00);
  end

  always_comb begin
    for (int k = 0; k < BYTES; k++) begin
      int unsigned span;
      int unsigned base;
      int unsigned top;
      logic        all_zero;
      span = 32'd1 << lg_i;
      base = 32'(k) & ~(span - 1);
      top  = base + span - 1;
      all_zero = 1'b1;
      for (int j = 0; j < 4; j++) begin
        if (32'(j) < span) all_zero &= byte_zero[base + 32'(j)];
      end
      lane_eq_o[k] = all_zero;
      // signed a<b: sign of a-b xor overflow, taken at the lane's top byte
      lane_lt_o[k] = diff_i[top*8 + 7] ^ ovf_i[top];
    end
  end
endmodule

// File: rtl/simd_mask_expand.sv
module simd_mask_expand #(
  parameter int unsigned BYTES = 16
) (
  input  logic [BYTES-1:0] mask_i,
  input  logic [1:0]       lg_i,
  output logic [BYTES-1:0] byte_en_o,
  output logic [BYTES-1:0] lane_start_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_en
    assign byte_en_o[k]    = mask_i[k >> lg_i];
    assign lane_start_o[k] = ((32'(k) & ((32'd1 << lg_i) - 1)) == 0);
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  localparam int unsigned BYTES = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] dst_old_i,
  input  logic [1:0]        esize_i,
  input  logic [2:0]        op_i,
  input  logic [BYTES-1:0]  mask_i,
  input  logic              zero_mode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  alu_op_e          op;
  logic [1:0]       lg;
  logic [BYTES-1:0] byte_en, lane_start, ovf, lane_eq, lane_lt;
  logic [DATA_W-1:0] sum, next_res;

  assign op = alu_op_e'(op_i);
  assign lg = lane_lg(esize_i);

  simd_mask_expand #(.BYTES(BYTES)) u_mask (
    .mask_i(mask_i), .lg_i(lg), .byte_en_o(byte_en), .lane_start_o(lane_start)
  );

  simd_part_adder #(.BYTES(BYTES)) u_add (
    .a_i(src_a_i), .b_i(src_b_i), .lane_start_i(lane_start),
    .sub_i(op != OP_ADD), .sum_o(sum), .ovf_o(ovf)
  );

  simd_lane_flags #(.BYTES(BYTES)) u_flags (
    .diff_i(sum), .ovf_i(ovf), .lg_i(lg), .lane_eq_o(lane_eq), .lane_lt_o(lane_lt)
  );

  always_comb begin
    for (int k = 0; k < BYTES; k++) begin
      logic [7:0] a_b, b_b, r_b;
      a_b = src_a_i[k*8 +: 8];
      b_b = src_b_i[k*8 +: 8];
      case (op)
        OP_ADD, OP_SUB: r_b = sum[k*8 +: 8];
        OP_CMPEQ:       r_b = {8{lane_eq[k]}};
        OP_CMPGT:       r_b = {8{~lane_eq[k] & ~lane_lt[k]}};
        OP_MIN:         r_b = lane_lt[k] ? a_b : b_b;
        OP_MAX:         r_b = lane_lt[k] ? b_b : a_b;
        default:        r_b = 8'h00;
      endcase
      if (byte_en[k])       next_res[k*8 +: 8] = r_b;
      else if (zero_mode_i) next_res[k*8 +: 8] = 8'h00;
      else                  next_res[k*8 +: 8] = dst_old_i[k*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end

  assert_valid_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  assert_lane_isolated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0 && esize_i == 2'd0 && mask_i[BYTES-1])
    |=> result_o[DATA_W-1 -: 8] == $past(src_a_i[DATA_W-1 -: 8] + src_b_i[DATA_W-1 -: 8]));
  assert_cmp_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && esize_i == 2'd0 && mask_i[0])
    |=> (result_o[7:0] == 8'h00 || result_o[7:0] == 8'hFF));
  assert_max_ge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5 && esize_i == 2'd2 && mask_i[0])
    |=> $signed(result_o[31:0]) >= $signed($past(src_a_i[31:0])));
  assert_merge_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_mode_i && mask_i == '0) |=> result_o == $past(dst_old_i));
  assert_zero_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_mode_i && mask_i == '0) |=> result_o == '0);
endmodule

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0, dst_old_i = '0;
  logic [1:0]   esize_i = '0;
  logic [2:0]   op_i = '0;
  logic [15:0]  mask_i = '0;
  logic         zero_mode_i = 1'b0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dst_old_i(dst_old_i), .esize_i(esize_i), .op_i(op_i),
    .mask_i(mask_i), .zero_mode_i(zero_mode_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [127:0] model(input logic [127:0] a, b, old,
      input logic [1:0] es, input logic [2:0] op, input logic [15:0] m, input logic zm);
    int w, n;
    logic [127:0] out;
    logic [31:0] lm, ea, eb, r;
    longint sa, sb;
    w  = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : 32;
    n  = 128 / w;
    lm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    out = '0;
    for (int i = 0; i < n; i++) begin
      ea = 32'(a >> (i*w)) & lm;
      eb = 32'(b >> (i*w)) & lm;
      sa = longint'(ea); if (ea[w-1]) sa = sa - (longint'(1) << w);
      sb = longint'(eb); if (eb[w-1]) sb = sb - (longint'(1) << w);
      case (op)
        3'd0: r = (ea + eb) & lm;
        3'd1: r = (ea - eb) & lm;
        3'd2: r = (ea == eb) ? lm : 32'd0;
        3'd3: r = (sa > sb) ? lm : 32'd0;
        3'd4: r = (sa < sb) ? ea : eb;
        3'd5: r = (sa > sb) ? ea : eb;
        default: r = 32'd0;
      endcase
      if (!m[i]) r = zm ? 32'd0 : (32'(old >> (i*w)) & lm);
      out |= 128'(r) << (i*w);
    end
    return out;
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [127:0] a, b, old,
      input logic [1:0] es, input logic [2:0] op, input logic [15:0] m, input logic zm);
    @(negedge clk);
    src_a_i = a; src_b_i = b; dst_old_i = old; esize_i = es; op_i = op;
    mask_i = m; zero_mode_i = zm; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, result_o, model(a, b, old, es, op, m, zm));
    check({req, " R2 valid"}, {127'd0, valid_o}, 128'd1);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result_o, '0);
    check("R1 valid", {127'd0, valid_o}, '0);
    rst_ni = 1'b1;

    // R4: carry cut at byte boundaries
    run("R4 add8", {16{8'hFF}}, {16{8'h01}}, '0, 2'd0, 3'd0, 16'hFFFF, 1'b0);
    check("R4 add8 literal", result_o, '0);
    run("R4 sub16", '0, {8{16'h0001}}, '0, 2'd1, 3'd1, 16'hFFFF, 1'b0);
    check("R4 sub16 literal", result_o, {8{16'hFFFF}});
    // R5: compares
    run("R5 eq32", {32'h1, 32'h5, 32'hFFFF_FFFF, 32'h0}, {32'h1, 32'h6, 32'hFFFF_FFFF, 32'h8},
        '0, 2'd2, 3'd2, 16'h000F, 1'b0);
    run("R5 gt32", {32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF},
        {32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000}, '0, 2'd2, 3'd3, 16'h000F, 1'b0);
    // R6: signed min/max
    run("R6 min8", {16{8'h80}}, {16{8'h7F}}, '0, 2'd0, 3'd4, 16'hFFFF, 1'b0);
    check("R6 min8 literal", result_o, {16{8'h80}});
    run("R6 max8", {16{8'h80}}, {16{8'h7F}}, '0, 2'd0, 3'd5, 16'hFFFF, 1'b0);
    check("R6 max8 literal", result_o, {16{8'h7F}});
    // R7: reserved codes
    run("R7 op6", rnd128(), rnd128(), rnd128(), 2'd1, 3'd6, 16'h00FF, 1'b0);
    run("R7 op7", rnd128(), rnd128(), rnd128(), 2'd0, 3'd7, 16'hFFFF, 1'b0);
    // R8: upper mask bits ignored at 32-bit width
    run("R8 mask upper", rnd128(), rnd128(), {4{32'hCAFE_F00D}}, 2'd2, 3'd0, 16'hFFF0, 1'b0);
    check("R8 literal", result_o, {4{32'hCAFE_F00D}});
    // R9 / R10: merge and zero modes
    run("R9 merge", rnd128(), rnd128(), rnd128(), 2'd1, 3'd1, 16'h00A5, 1'b0);
    run("R10 zero", rnd128(), rnd128(), rnd128(), 2'd0, 3'd0, 16'h5A3C, 1'b1);
    // R3: code 3 behaves as 32-bit lanes
    run("R3 esize3", {4{32'h0000_FFFF}}, {4{32'h0000_0001}}, '0, 2'd3, 3'd0, 16'h000F, 1'b0);
    check("R3 literal", result_o, {4{32'h0001_0000}});

    // R2: idle cycle holds result
    held = result_o;
    @(negedge clk);
    src_a_i = rnd128(); src_b_i = rnd128(); dst_old_i = rnd128(); mask_i = 16'hFFFF;
    @(negedge clk);
    check("R2 hold", result_o, held);
    check("R2 idle valid", {127'd0, valid_o}, '0);

    for (int t = 0; t < 400; t++) begin
      logic [2:0] op;
      string tag;
      op = 3'($urandom_range(0, 7));
      tag = (op < 2) ? "R4 rand" : (op < 4) ? "R5 rand" : (op < 6) ? "R6 rand" : "R7 rand";
      run({tag, " R3 R8 R9 R10"}, rnd128(), rnd128(), rnd128(), 2'($urandom_range(0, 3)),
          op, 16'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule